// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block arbitrates eight interrupt request lines for a processor. It holds the request, mask and in-service registers and a rotation offset that sets which line currently has top priority. On every clock it checks whether the best pending, unmasked request outranks everything already in service. The result appears on a registered interrupt output one cycle later. When the processor acknowledges, the block returns a vector made from a programmable base and the winning line number, and it updates the in-service state.

Software controls the block through byte writes to a two-address port. A start word on address 0 begins a short programming sequence on address 1: vector base, an optional cascade word, and an optional mode word. After that sequence, address-1 writes load the mask. Other address-0 writes either choose what a read returns and arm a poll, or carry an end-of-interrupt or rotation command. Requests arrive as one-cycle set pulses on `req_set_i`, because edge detection is done upstream.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the irq output is 0, and the request, in-service and mask registers read as 0. The rotation offset is 0, so line 0 outranks line 7.
- R2: Priority is found by scanning from the line equal to the rotation offset upward, wrapping modulo 8, and the first set line wins. The acknowledge vector is the vector base OR the winning line number.
- R3: irq_o goes high one cycle after a state in which the best unmasked pending request has a strictly better priority than the best in-service line. Masked requests are ignored, and a request with equal or lower priority than an in-service line keeps irq_o low.
- R4: An address-0 write with bit 4 set starts programming. It clears the request, mask and in-service registers, the offset and all mode flags, and irq_o reads 0 on the following cycle. Bit 0 of that write says a mode word follows, and bit 1 selects single mode.
- R5: The first address-1 write after the start word sets the vector base to data AND 0xF8. A cascade word follows unless single mode is on. The mode word, if enabled, sets the nested flag (nested_o) from bit 4 and auto-EOI from bit 1. After the sequence, address-1 writes load the mask.
- R6: An address-0 write with bit 3 set and bit 4 clear is a read-select command. Bit 1 enables loading the select from bit 0 (1 selects in-service, 0 selects request). Bit 6 enables loading special-mask mode from bit 5. Address-0 reads return the selected register, and address-1 reads return the mask.
- R7: In special-mask mode, in-service bits that are masked are left out of the comparison in R3.
- R8: An acknowledge without auto-EOI sets the winner's in-service bit and clears its request bit. With no winner, the acknowledge returns base OR 7 and changes nothing. In-service bits are set only by an acknowledge.
- R9: An acknowledge with auto-EOI sets no in-service bit. If rotate-on-auto-EOI is on, the offset becomes the line plus 1. Command code 4 (bits 7:5) turns rotate-on-auto-EOI on, and code 0 turns it off.
- R10: Command code 1 clears the in-service bit with the best rotated priority. Code 5 does the same and then sets the offset to that line plus 1.
- R11: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and sets the offset to that line plus 1. Code 6 sets the offset to bits 2:0 plus 1. Code 2 changes nothing.
- R12: An address-0 write with bits 3 and 2 set arms a poll. The next read, at either address, returns the winning line and clears that line's request and in-service bits, or returns 7 if there is no winner. The poll is then disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_i | input | 8 | One-cycle pulses that set request bits |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 1 | Port address (0 or 1) |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe (needed for poll side effects) |
| rdata_o | output | 8 | Read data |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_vec_o | output | 8 | Vector returned for the acknowledge |
| irq_o | output | 1 | Registered interrupt request to the processor |
| nested_o | output | 1 | Nested-mode flag from the mode word |

## Verification
The hardest state to reach from the ports is a stack of in-service lines under a rotated offset. That is the state where a non-specific end-of-interrupt must clear the highest-ranking in-service line by rotated order rather than by line number. The bench builds it in steps. It rotates the offset with a set-priority command, acknowledges one line, and issues a rotating end-of-interrupt that moves the offset again. It then lets a line that now outranks the in-service line nest on top of it. Special-mask mode is reached in a similar way: one line is left in service, a lower-priority line is raised, and the in-service line is then masked, which must let the lower-priority line through.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);
    localparam int PW    = LW + 1;
    localparam int DW    = 8;

    localparam logic [DW-1:0] BASE_KEEP = {{(DW-LW){1'b1}}, {LW{1'b0}}};
    localparam logic [LW-1:0] SPUR_LINE = LW'(LINES - 1);

    typedef enum logic [1:0] {
        ST_RUN,
        ST_BASE,
        ST_LINK,
        ST_MODE
    } init_st_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_INIT,
        CK_RSEL,
        CK_OP,
        CK_DATA
    } cmd_kind_e;

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] line;
        logic [PW-1:0] prio;
    } pick_t;

    typedef struct packed {
        cmd_kind_e     kind;
        logic [2:0]    code;
        logic [LW-1:0] lvl;
        logic          poll;
        logic          rsel_ld;
        logic          rsel;
        logic          smm_ld;
        logic          smm;
        logic          want_w4;
        logic          single;
        logic [DW-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic [LINES-1:0] irr;
        logic [LINES-1:0] imr;
        logic [LINES-1:0] isr;
        logic [LW-1:0]    off;
        logic [DW-1:0]    base;
        logic             rsel;
        logic             poll;
        logic             smm;
        logic             aeoi;
        logic             rot_aeoi;
        logic             nested;
        logic             want_w4;
        logic             single;
        init_st_e         ist;
    } ctrl_t;

    function automatic logic [LINES-1:0] line_bit(input logic [LW-1:0] l);
        return LINES'(1) << l;
    endfunction

    function automatic logic [LW-1:0] after_line(input logic [LW-1:0] l);
        return l + LW'(1);
    endfunction

endpackage

// File: rtl/prio_pick.sv
module prio_pick
    import irq_pkg::*;
(
    input  logic [LINES-1:0] bits,
    input  logic [LW-1:0]    offset,
    output pick_t            pick
);

    logic [LINES-1:0] rot;

    for (genvar p = 0; p < LINES; p++) begin : g_rot
        logic [LW-1:0] idx;
        assign idx    = LW'(p) + offset;
        assign rot[p] = bits[idx];
    end

    always_comb begin
        pick.prio = PW'(LINES);
        for (int p = LINES - 1; p >= 0; p--) begin
            if (rot[p]) pick.prio = PW'(p);
        end
        pick.valid = |bits;
        pick.line  = pick.prio[LW-1:0] + offset;
    end

endmodule

// File: rtl/cmd_dec.sv
module cmd_dec
    import irq_pkg::*;
(
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] data,
    output cmd_t          cmd
);

    always_comb begin
        if (!wr_en)       cmd.kind = CK_NONE;
        else if (addr)    cmd.kind = CK_DATA;
        else if (data[4]) cmd.kind = CK_INIT;
        else if (data[3]) cmd.kind = CK_RSEL;
        else              cmd.kind = CK_OP;
        cmd.code    = data[7:5];
        cmd.lvl     = data[LW-1:0];
        cmd.poll    = data[2];
        cmd.rsel_ld = data[1];
        cmd.rsel    = data[0];
        cmd.smm_ld  = data[6];
        cmd.smm     = data[5];
        cmd.want_w4 = data[0];
        cmd.single  = data[1];
        cmd.data    = data;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req_set_i,
    input  logic             wr_en_i,
    input  logic             addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             rd_en_i,
    output logic [DW-1:0]    rdata_o,
    input  logic             ack_i,
    output logic [DW-1:0]    ack_vec_o,
    output logic             irq_o,
    output logic             nested_o
);

    ctrl_t st, nx;
    cmd_t  cmd;
    pick_t req_pk, cmp_pk, isr_pk;

    logic [LINES-1:0] pend, isr_cmp;
    logic             win_valid;
    logic [LW-1:0]    win_line;

    cmd_dec u_dec (
        .wr_en (wr_en_i),
        .addr  (addr_i),
        .data  (wdata_i),
        .cmd   (cmd)
    );

    assign pend    = st.irr & ~st.imr;
    assign isr_cmp = st.smm ? (st.isr & ~st.imr) : st.isr;

    prio_pick u_req (.bits(pend),    .offset(st.off), .pick(req_pk));
    prio_pick u_cmp (.bits(isr_cmp), .offset(st.off), .pick(cmp_pk));
    prio_pick u_isr (.bits(st.isr),  .offset(st.off), .pick(isr_pk));

    assign win_valid = req_pk.valid && (req_pk.prio < cmp_pk.prio);
    assign win_line  = req_pk.line;

    always_comb begin
        nx = st;
        unique case (cmd.kind)
            CK_INIT: begin
                nx.imr      = '0;
                nx.isr      = '0;
                nx.off      = '0;
                nx.base     = '0;
                nx.rsel     = 1'b0;
                nx.poll     = 1'b0;
                nx.smm      = 1'b0;
                nx.aeoi     = 1'b0;
                nx.rot_aeoi = 1'b0;
                nx.nested   = 1'b0;
                nx.want_w4  = cmd.want_w4;
                nx.single   = cmd.single;
                nx.ist      = ST_BASE;
            end
            CK_RSEL: begin
                if (cmd.poll)    nx.poll = 1'b1;
                if (cmd.rsel_ld) nx.rsel = cmd.rsel;
                if (cmd.smm_ld)  nx.smm  = cmd.smm;
            end
            CK_OP: begin
                unique case (cmd.code)
                    3'd0, 3'd4: nx.rot_aeoi = cmd.code[2];
                    3'd1, 3'd5: begin
                        if (isr_pk.valid) begin
                            nx.isr = st.isr & ~line_bit(isr_pk.line);
                            if (cmd.code[2]) nx.off = after_line(isr_pk.line);
                        end
                    end
                    3'd3: nx.isr = st.isr & ~line_bit(cmd.lvl);
                    3'd6: nx.off = after_line(cmd.lvl);
                    3'd7: begin
                        nx.isr = st.isr & ~line_bit(cmd.lvl);
                        nx.off = after_line(cmd.lvl);
                    end
                    default: ;
                endcase
            end
            CK_DATA: begin
                unique case (st.ist)
                    ST_RUN:  nx.imr = cmd.data;
                    ST_BASE: begin
                        nx.base = cmd.data & BASE_KEEP;
                        if (st.single) nx.ist = st.want_w4 ? ST_MODE : ST_RUN;
                        else           nx.ist = ST_LINK;
                    end
                    ST_LINK: nx.ist = st.want_w4 ? ST_MODE : ST_RUN;
                    ST_MODE: begin
                        nx.nested = cmd.data[4];
                        nx.aeoi   = cmd.data[1];
                        nx.ist    = ST_RUN;
                    end
                    default: ;
                endcase
            end
            default: begin
                if (rd_en_i && st.poll) begin
                    nx.poll = 1'b0;
                    if (win_valid) begin
                        nx.irr = st.irr & ~line_bit(win_line);
                        nx.isr = st.isr & ~line_bit(win_line);
                    end
                end else if (ack_i && win_valid) begin
                    if (st.aeoi) begin
                        if (st.rot_aeoi) nx.off = after_line(win_line);
                    end else begin
                        nx.isr = st.isr | line_bit(win_line);
                    end
                    nx.irr = st.irr & ~line_bit(win_line);
                end
            end
        endcase
        if (cmd.kind == CK_INIT) nx.irr = req_set_i;
        else                     nx.irr = nx.irr | req_set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            irq_o <= 1'b0;
        end else begin
            st    <= nx;
            irq_o <= (cmd.kind == CK_INIT) ? 1'b0 : win_valid;
        end
    end

    always_comb begin
        if (st.poll)     rdata_o = win_valid ? DW'(win_line) : DW'(SPUR_LINE);
        else if (addr_i) rdata_o = st.imr;
        else             rdata_o = st.rsel ? st.isr : st.irr;
    end

    assign ack_vec_o = st.base | (win_valid ? DW'(win_line) : DW'(SPUR_LINE));
    assign nested_o  = st.nested;

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             addr,
    input logic [DW-1:0]    wdata,
    input logic             rd_en,
    input logic             ack,
    input logic             irq,
    input logic [LINES-1:0] irr,
    input logic [LINES-1:0] imr,
    input logic [LINES-1:0] isr,
    input logic             aeoi,
    input logic             poll,
    input logic             win_valid,
    input logic [LW-1:0]    win_line
);

    assert_init_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> (!irq && isr == '0 && imr == '0));

    assert_ack_sets_isr_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && !wr_en && !rd_en && win_valid && !aeoi) |=> isr[$past(win_line)]);

    assert_isr_only_by_ack_R8: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ((isr & ~$past(isr)) == '0));

    assert_aeoi_keeps_isr_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !wr_en && !rd_en && aeoi) |=> (isr == $past(isr)));

    assert_poll_once_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && poll) |=> !poll);

    assert_irq_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(irr & ~imr) != '0));

endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en_i),
    .addr      (addr_i),
    .wdata     (wdata_i),
    .rd_en     (rd_en_i),
    .ack       (ack_i),
    .irq       (irq_o),
    .irr       (st.irr),
    .imr       (st.imr),
    .isr       (st.isr),
    .aeoi      (st.aeoi),
    .poll      (st.poll),
    .win_valid (win_valid),
    .win_line  (win_line)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_set = '0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic [7:0] ack_vec;
    logic       irq;
    logic       nested;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .req_set_i (req_set),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rd_en_i   (rd_en),
        .rdata_o   (rdata),
        .ack_i     (ack),
        .ack_vec_o (ack_vec),
        .irq_o     (irq),
        .nested_o  (nested)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input string tag, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 chk(tag, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_ack(input string tag, input logic [7:0] exp);
        @(negedge clk);
        ack = 1'b1;
        #1 chk(tag, ack_vec, exp);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic raise(input logic [7:0] b);
        @(negedge clk);
        req_set = b;
        @(negedge clk);
        req_set = '0;
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        @(negedge clk);
        chk(tag, {7'd0, irq}, {7'd0, exp});
    endtask

    task automatic ini(input logic [7:0] base, input logic aeoi);
        wr(1'b0, 8'h11);
        wr(1'b1, base);
        wr(1'b1, 8'h00);
        wr(1'b1, {6'd0, aeoi, 1'b0});
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd(1'b1, "R1 mask after reset", 8'h00);
        rd(1'b0, "R1 request after reset", 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R1 in-service after reset", 8'h00);
        raise(8'h81);
        do_ack("R1 offset zero favours line 0", 8'h00);
    endtask

    task automatic t_init_drop();
        ini(8'h20, 1'b0);
        raise(8'h04);
        chk_irq("R3 irq for pending line", 1'b1);
        wr(1'b0, 8'h11);
        chk("R4 irq dropped by init", {7'd0, irq}, 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
        rd(1'b1, "R4 mask cleared", 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, "R4 request cleared", 8'h00);
        do_ack("R8 spurious ack vector", 8'h27);
    endtask

    task automatic t_basic();
        ini(8'h20, 1'b0);
        raise(8'h28);
        chk_irq("R3 irq raised", 1'b1);
        wr(1'b0, 8'h0A);
        rd(1'b0, "R6 request read", 8'h28);
        do_ack("R2 best line 3", 8'h23);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R8 in-service after ack", 8'h08);
        chk_irq("R3 lower line blocked by service", 1'b0);
        wr(1'b0, 8'h20);
        chk_irq("R3 irq after EOI", 1'b1);
        do_ack("R2 next line 5", 8'h25);
        wr(1'b0, 8'h20);
        rd(1'b0, "R10 in-service empty", 8'h00);
        wr(1'b1, 8'h01);
        raise(8'h01);
        chk_irq("R3 masked request ignored", 1'b0);
        rd(1'b1, "R6 mask read", 8'h01);
        wr(1'b1, 8'h00);
        chk_irq("R3 unmasked request seen", 1'b1);
        do_ack("R2 line 0 vector", 8'h20);
        wr(1'b0, 8'h20);
        do_ack("R8 spurious vector", 8'h27);
        rd(1'b0, "R8 spurious leaves in-service", 8'h00);
    endtask

    task automatic t_rotate();
        ini(8'h00, 1'b0);
        wr(1'b0, 8'hC2);
        raise(8'h12);
        do_ack("R11 set-priority puts line 4 first", 8'h04);
        wr(1'b0, 8'hA0);
        do_ack("R10 rotating EOI leaves line 1", 8'h01);
        raise(8'h40);
        chk_irq("R10 line 6 nests over line 1", 1'b1);
        do_ack("R10 nested ack line 6", 8'h06);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R8 two lines in service", 8'h42);
        wr(1'b0, 8'h20);
        rd(1'b0, "R10 non-specific clears rotated best", 8'h02);
        wr(1'b0, 8'h61);
        rd(1'b0, "R11 specific EOI", 8'h00);
        raise(8'h04);
        do_ack("R2 line 2 alone", 8'h02);
        wr(1'b0, 8'hE2);
        rd(1'b0, "R11 rotate specific clears", 8'h00);
        raise(8'h0C);
        do_ack("R11 offset now 3", 8'h03);
        wr(1'b0, 8'h40);
        rd(1'b0, "R11 code 2 no effect", 8'h08);
        wr(1'b0, 8'h20);
        do_ack("R2 remaining line 2", 8'h02);
        wr(1'b0, 8'h20);
        rd(1'b0, "R10 all cleared", 8'h00);
    endtask

    task automatic t_aeoi();
        ini(8'h40, 1'b1);
        chk("R5 nested off", {7'd0, nested}, 8'h00);
        wr(1'b0, 8'h80);
        raise(8'h05);
        do_ack("R9 first ack line 0", 8'h40);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R9 no in-service bit", 8'h00);
        raise(8'h01);
        do_ack("R9 rotated to line 2", 8'h42);
        raise(8'h08);
        do_ack("R9 rotated to line 3", 8'h43);
        wr(1'b0, 8'h00);
        do_ack("R9 line 0 after rotation", 8'h40);
        raise(8'h11);
        do_ack("R9 offset held at 4", 8'h44);
        do_ack("R9 line 0 last", 8'h40);
        rd(1'b0, "R9 in-service still empty", 8'h00);
    endtask

    task automatic t_single();
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h6F);
        wr(1'b1, 8'h80);
        rd(1'b1, "R5 single skips cascade word", 8'h80);
        raise(8'h02);
        do_ack("R5 base masked to 68", 8'h69);
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h12);
        chk("R5 nested flag from mode word", {7'd0, nested}, 8'h01);
        wr(1'b1, 8'h55);
        rd(1'b1, "R5 mask after mode word", 8'h55);
    endtask

    task automatic t_smm();
        ini(8'h00, 1'b0);
        raise(8'h20);
        do_ack("R2 line 5", 8'h05);
        raise(8'h40);
        chk_irq("R7 line 6 blocked", 1'b0);
        wr(1'b0, 8'h68);
        wr(1'b1, 8'h20);
        chk_irq("R7 special mask lets line 6 in", 1'b1);
        wr(1'b0, 8'h48);
        chk_irq("R7 special mask off blocks again", 1'b0);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h65);
        chk_irq("R11 line 6 after specific EOI", 1'b1);
        do_ack("R2 line 6", 8'h06);
        wr(1'b0, 8'h20);
    endtask

    task automatic t_poll();
        ini(8'h00, 1'b0);
        raise(8'h90);
        wr(1'b0, 8'h0A);
        wr(1'b0, 8'h0C);
        rd(1'b0, "R12 poll returns line 4", 8'h04);
        rd(1'b0, "R12 poll cleared request", 8'h80);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R12 poll set no in-service", 8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b1, "R12 poll at address 1 gives line 7", 8'h07);
        wr(1'b0, 8'h0C);
        rd(1'b0, "R12 empty poll gives 7", 8'h07);
        rd(1'b1, "R12 poll disarmed", 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before all R tests ended");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_init_drop();
        t_basic();
        t_rotate();
        t_aeoi();
        t_single();
        t_smm();
        t_poll();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule